// File: doc/BRIEF.md
# Cable-Presence Detect Glitch Filter

This block cleans up the 5 V cable-presence detect signal of a serial video receiver. The raw level is first brought into a free-running local filter clock domain. It is then qualified by an asymmetric filter. The filtered level goes high only after the detect has stayed high, without a break, for a programmable number of two-cycle units. It drops again as soon as the detect falls. Because the filter clock is a local oscillator of roughly 42 MHz, detection keeps working while the rest of the receiver is powered down.

The filtered level is used in three ways. It is an output in its own right. Every change of it produces a one-cycle interrupt pulse. It also drives a reset request that holds the receiver section in reset while no cable is seen. A disconnect bit removes that reset request, for boards that leave the detect pin unconnected. A bypass bit skips the qualification time altogether.

Top module: `cable_det_filter`

## Requirements
- R1: The raw detect input passes through two flip-flops clocked by the filter clock before it reaches the qualifier. The filter logic never samples the raw pin directly.
- R2: With bypass 0 and a timer setting T of 1 or more, `det_level` first reads 1 at the 2T+3 rising clock edge after a rise of the raw input. The edges are counted from the first edge that samples the new raw value. The raw input must stay high throughout.
- R3: A fall of the raw input clears `det_level` at the 4th rising clock edge, whatever the timer setting or bypass value.
- R4: A raw high pulse shorter than 2T clock cycles never sets `det_level`.
- R5: A timer setting of 0 adds no qualification time: `det_level` follows a raw rise at the 4th rising clock edge.
- R6: With `filt_bypass` at 1, `det_level` follows a raw rise at the 4th rising clock edge, whatever value `timer_cfg` holds.
- R7: `det_int` is high for exactly one clock cycle, in the same cycle in which `det_level` takes a new value, on both rising and falling changes. At all other times it is low.
- R8: `rx_rst` is 1 exactly when `det_level` is 0 and `rst_detach` is 0. While `rst_detach` is 1, `rx_rst` is 0.
- R9: While `rst_n` is low, `det_level` and `det_int` are 0, and `rx_rst` equals the inverse of `rst_detach`.
- R10: The largest timer setting, 127, makes a qualification time of 254 cycles. The counter does not wrap during it, so `det_level` first reads 1 at the 257th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running filter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_raw | input | 1 | Unsynchronized cable-presence level |
| filt_bypass | input | 1 | 1 skips the qualification time |
| timer_cfg | input | 7 | Qualification time in units of two clock cycles |
| rst_detach | input | 1 | 1 stops the detect from driving the receiver reset |
| det_level | output | 1 | Filtered cable-presence level |
| det_int | output | 1 | One-cycle pulse on each change of `det_level` |
| rx_rst | output | 1 | Reset request for the receiver section |

## Verification
Suppose the run counter were off by one, or wrapped. Then `det_level` would rise one edge early, one edge late, or never, so the rise checks are placed on the exact edge and on the edge before it. A qualifier that failed to clear on a low input would show in two ways. A short glitch would set the level. A falling detect would show up later than the fourth edge. A stale output register would shift `det_int` out of line with the level change, and the bench would see this within a single cycle. A wrong gate on the reset path would show at once on `rx_rst`, whenever `rst_detach` or the level changes.

// File: rtl/cdf_pkg.sv
package cdf_pkg;

    typedef struct packed {
        logic lvl;
        logic pulse;
    } out_state_t;

endpackage

// File: rtl/cdf_sync.sv
module cdf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            // R1: output is the input from two edges earlier once out of reset
            a_r1_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n, 2) |-> (dout == $past(din, 2)));
        end
    endgenerate
endmodule

// File: rtl/cdf_qualify.sv
module cdf_qualify #(
    parameter int TIMER_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               det_s,
    input  logic               bypass,
    input  logic [TIMER_W-1:0] timer,
    output logic               hold
);
    localparam int RUN_W = TIMER_W + 1;

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             hold;
    } qual_state_t;

    qual_state_t st_d, st_q;
    logic [RUN_W:0] len;
    logic [RUN_W:0] target;

    always_comb begin
        len    = {1'b0, st_q.run} + 1'b1;
        target = {1'b0, timer, 1'b0};
        st_d   = st_q;
        if (!det_s) begin
            st_d.run  = '0;
            st_d.hold = 1'b0;
        end else begin
            if (st_q.run != {RUN_W{1'b1}}) st_d.run = st_q.run + 1'b1;
            st_d.hold = bypass | (len >= target);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold = st_q.hold;

    // R3: a low synchronized input clears the qualified level on the next edge
    a_r3_drop_now: assert property (@(posedge clk) disable iff (!rst_n)
        !det_s |=> !hold);
    // R4: the qualified level is never set without a high input on the prior edge
    a_r4_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> $past(det_s));
    // R6: bypass lets a high input through on the next edge
    a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && det_s) |=> hold);
endmodule

// File: rtl/cdf_outstage.sv
module cdf_outstage
    import cdf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic detach,
    output logic level,
    output logic pulse,
    output logic rst_req
);
    out_state_t os_d, os_q;

    always_comb begin
        os_d       = os_q;
        os_d.lvl   = hold;
        os_d.pulse = hold ^ os_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) os_q <= '0;
        else        os_q <= os_d;
    end

    assign level   = os_q.lvl;
    assign pulse   = os_q.pulse;
    assign rst_req = ~os_q.lvl & ~detach;

    // R7: every change of the level carries an interrupt pulse, and only then
    a_r7_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> pulse);
    a_r7_no_idle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(level) |-> !pulse);
    // R8: reset request is gated off by detach and never asserted with a cable seen
    a_r8_detach_gate: assert property (@(posedge clk) disable iff (!rst_n)
        detach |-> !rst_req);
    a_r8_level_gate: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !level);
endmodule

// File: rtl/cable_det_filter.sv
module cable_det_filter #(
    parameter int TIMER_W     = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               det_raw,
    input  logic               filt_bypass,
    input  logic [TIMER_W-1:0] timer_cfg,
    input  logic               rst_detach,
    output logic               det_level,
    output logic               det_int,
    output logic               rx_rst
);
    logic det_s;
    logic hold;

    cdf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (det_raw),
        .dout (det_s)
    );

    cdf_qualify #(.TIMER_W(TIMER_W)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .det_s (det_s),
        .bypass(filt_bypass),
        .timer (timer_cfg),
        .hold  (hold)
    );

    cdf_outstage u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (hold),
        .detach (rst_detach),
        .level  (det_level),
        .pulse  (det_int),
        .rst_req(rx_rst)
    );
endmodule

// File: tb/sim_cable_det_filter.sv
`timescale 1ns/1ps
module sim_cable_det_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       det_raw = 1'b0;
    logic       filt_bypass = 1'b0;
    logic [6:0] timer_cfg = 7'd0;
    logic       rst_detach = 1'b0;
    logic       det_level, det_int, rx_rst;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cable_det_filter u0 (
        .clk(clk), .rst_n(rst_n), .det_raw(det_raw), .filt_bypass(filt_bypass),
        .timer_cfg(timer_cfg), .rst_detach(rst_detach),
        .det_level(det_level), .det_int(det_int), .rx_rst(rx_rst)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // return to idle: raw low, level low
    task automatic settle();
        det_raw = 1'b0;
        filt_bypass = 1'b0;
        edges(8);
    endtask

    task automatic t_reset();
        check(det_level, 1'b0, "R9 level in reset");
        check(det_int, 1'b0, "R9 int in reset");
        check(rx_rst, 1'b1, "R9 rx_rst in reset");
        rst_detach = 1'b1; #1;
        check(rx_rst, 1'b0, "R9 rx_rst detached in reset");
        rst_detach = 1'b0; #1;
        rst_n = 1'b1;
        edges(2);
        check(det_level, 1'b0, "R9 level after reset");
    endtask

    // rise with timer t (t>=1): level at edge 2t+3, not at 2t+2
    task automatic t_rise(input int t, input string tag);
        timer_cfg = 7'(t);
        det_raw = 1'b1;
        edges(2*t + 2);
        check(det_level, 1'b0, {tag, " not early"});
        check(det_int, 1'b0, {tag, " no early int"});
        edges(1);
        check(det_level, 1'b1, {tag, " on time"});
        check(det_int, 1'b1, {tag, " R7 rise pulse"});
        check(rx_rst, 1'b0, "R8 rx_rst off with cable");
        edges(1);
        check(det_int, 1'b0, "R7 pulse one cycle");
        check(det_level, 1'b1, {tag, " stays"});
    endtask

    task automatic t_fall();
        det_raw = 1'b0;
        edges(3);
        check(det_level, 1'b1, "R3 fall not before 4th edge");
        edges(1);
        check(det_level, 1'b0, "R3 fall at 4th edge");
        check(det_int, 1'b1, "R7 fall pulse");
        check(rx_rst, 1'b1, "R8 rx_rst on without cable");
        edges(1);
        check(det_int, 1'b0, "R7 fall pulse one cycle");
    endtask

    task automatic t_glitch();
        int seen = 0;
        timer_cfg = 7'd3;
        det_raw = 1'b1;
        edges(5);
        det_raw = 1'b0;
        for (int i = 0; i < 20; i++) begin
            edges(1);
            if (det_level || det_int) seen++;
        end
        check(seen != 0, 1'b0, "R4 short pulse ignored");
        det_raw = 1'b1;
        edges(3);
        det_raw = 1'b0;
        edges(1);
        det_raw = 1'b1;
        edges(3);
        det_raw = 1'b0;
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            edges(1);
            if (det_level) seen++;
        end
        check(seen != 0, 1'b0, "R4 broken high run ignored");
    endtask

    task automatic t_zero();
        timer_cfg = 7'd0;
        det_raw = 1'b1;
        edges(3);
        check(det_level, 1'b0, "R5 zero timer not before 4th");
        edges(1);
        check(det_level, 1'b1, "R5 zero timer at 4th");
        settle();
    endtask

    task automatic t_bypass();
        timer_cfg = 7'd100;
        filt_bypass = 1'b1;
        det_raw = 1'b1;
        edges(3);
        check(det_level, 1'b0, "R6 bypass not before 4th");
        edges(1);
        check(det_level, 1'b1, "R6 bypass at 4th");
        det_raw = 1'b0;
        edges(4);
        check(det_level, 1'b0, "R3 bypass fall at 4th");
        settle();
    endtask

    task automatic t_detach();
        check(rx_rst, 1'b1, "R8 idle reset request");
        rst_detach = 1'b1; #1;
        check(rx_rst, 1'b0, "R8 detach removes request");
        timer_cfg = 7'd1;
        det_raw = 1'b1;
        edges(6);
        check(rx_rst, 1'b0, "R8 detach with cable");
        det_raw = 1'b0;
        edges(6);
        check(rx_rst, 1'b0, "R8 detach after fall");
        rst_detach = 1'b0; #1;
        check(rx_rst, 1'b1, "R8 reattach restores request");
    endtask

    initial begin
        edges(3);
        t_reset();
        t_rise(3, "R2 T=3");
        t_fall();
        t_rise(1, "R2 T=1");
        t_fall();
        t_glitch();
        t_zero();
        t_bypass();
        t_detach();
        t_rise(127, "R10 T=127");
        t_fall();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule